// File: doc/BRIEF.md
# Grouped Interrupt Status Encoder

The block collects raw interrupt requests from three groups, critical, main and peripheral, and turns them into one registered status word. For each group the word shows whether a request is pending and which source it is. The lowest-numbered pending source in a group wins. Per-source mask registers gate the requests. A per-peripheral boost setting can promote a peripheral source so that it also shows up in the critical or main field, under a reserved code.

A second registered output gives the single request that an interrupt handler should serve first. It is a group number and a source number, packed into an 8-bit identifier. Groups are ordered critical, then main, then peripheral. When the winning field holds a reserved boost code, the identifier names the peripheral that the peripheral field reports. A small write port loads the masks and the boost settings.

Top module: `grp_irq_encoder`

## Requirements
- R1: After reset the status word and all combined outputs are 0. Every mask bit is 1, so raw requests produce no pending indication until they are unmasked.
- R2: Status word layout. Critical: flag at bit 10, source at bits 9:8. Main: flag at bit 21, source at bits 20:16. Peripheral: flag at bit 29, source at bits 28:24. All other bits are 0, and the source field of a group with nothing pending is 0.
- R3: Within each group the lowest-numbered pending, unmasked source is reported.
- R4: Writing 1 to a mask bit disables its source. Write addresses: 0 is the critical mask, with source n at bit n. 1 is the main mask, with source n at bit 16−n. 2 is the peripheral mask, with source n at bit 31−n.
- R5: Raw critical line 2 and raw main line 4 are reserved and never cause a pending indication.
- R6: A pending, unmasked high-boost peripheral makes critical code 2 pending. A pending, unmasked medium-boost peripheral makes main code 4 pending. In both cases the peripheral field carries the peripheral number.
- R7: The peripheral field reports the lowest high-boost source if there is one. Otherwise it reports the lowest medium-boost source, and otherwise the lowest unboosted source.
- R8: The combined output follows group priority critical, then main, then peripheral. A critical code 2 or a main code 4 is reported as group 2 with the peripheral field's source.
- R9: The identifier is group×64 + source, with group codes 0 critical, 1 main, 2 peripheral. With nothing pending, the valid output is 0 and group, source and identifier are all 0.
- R10: Outputs reflect the requests and register values present at the previous rising clock edge. A register write affects the outputs one edge after the write edge.
- R11: Boost settings are 2 bits per peripheral. Address 3 holds peripherals 0–15 and address 4 holds peripherals 16–31; peripheral k uses bits 2(k mod 16)+1:2(k mod 16). Value 01 means medium, 10 or 11 means high, and 00 means none. Addresses 5–7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crit_req_i | input | N_CRIT (4) | Raw critical requests |
| main_req_i | input | N_MAIN (17) | Raw main requests |
| peri_req_i | input | N_PERI (32) | Raw peripheral requests; source 0 is the DMA summary |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| status_o | output | 32 | Encoded per-group status word |
| pend_valid_o | output | 1 | A request is pending somewhere |
| pend_group_o | output | 2 | Group of the highest pending request |
| pend_src_o | output | 6 | Source number within that group |
| pend_id_o | output | 8 | Packed identifier group×64 + source |

## Verification
The assertions run on every cycle. They check that each finder reports a pending line with no lower pending line. They check that a reserved code in the critical or main field is backed by a peripheral flag and redirects the combined output to group 2. They also check that the combined group never skips a higher pending group, and that idle inputs give an idle output one cycle later. Mask bit mirroring, the boost register layout, the class ordering inside the peripheral field and the write-to-effect latency are register-dependent. Only the bench's scenarios show these, by comparing against its cycle-by-cycle model after directed and random writes.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int CRIT_FW        = 2;
  localparam int MAIN_FW        = 5;
  localparam int PERI_FW        = 5;
  localparam int SRC_W          = 6;
  localparam int GRP_W          = 2;
  localparam int CRIT_BOOST_IDX = 2;
  localparam int MAIN_BOOST_IDX = 4;
  localparam int CRIT_FLAG_BIT  = 10;
  localparam int CRIT_LSB       = 8;
  localparam int MAIN_FLAG_BIT  = 21;
  localparam int MAIN_LSB       = 16;
  localparam int PERI_FLAG_BIT  = 29;
  localparam int PERI_LSB       = 24;
  localparam int ADDR_CRIT_MASK = 0;
  localparam int ADDR_MAIN_MASK = 1;
  localparam int ADDR_PERI_MASK = 2;
  localparam int ADDR_BOOST0    = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_CRIT = 2'd0,
    GRP_MAIN = 2'd1,
    GRP_PERI = 2'd2
  } grp_e;
endpackage

// File: rtl/grp_irq_cfg.sv
module grp_irq_cfg
  import grp_irq_pkg::*;
#(
  parameter int N_CRIT = 4,
  parameter int N_MAIN = 17,
  parameter int N_PERI = 32,
  parameter int DW     = 32,
  parameter int AW     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [N_CRIT-1:0]   crit_mask_o,
  output logic [N_MAIN-1:0]   main_mask_o,
  output logic [N_PERI-1:0]   peri_mask_o,
  output logic [2*N_PERI-1:0] boost_o
);
  localparam int PER_WORD = DW / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_mask_o <= '1;
      main_mask_o <= '1;
      peri_mask_o <= '1;
      boost_o     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADDR_CRIT_MASK)) crit_mask_o <= wr_data_i[N_CRIT-1:0];
      if (wr_addr_i == AW'(ADDR_MAIN_MASK)) main_mask_o <= wr_data_i[N_MAIN-1:0];
      if (wr_addr_i == AW'(ADDR_PERI_MASK)) peri_mask_o <= wr_data_i[N_PERI-1:0];
      for (int p = 0; p < N_PERI; p++) begin
        if (wr_addr_i == AW'(ADDR_BOOST0 + p / PER_WORD))
          boost_o[2*p +: 2] <= wr_data_i[2*(p % PER_WORD) +: 2];
      end
    end
  end
endmodule

// File: rtl/grp_irq_lowest.sv
module grp_irq_lowest #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found_o) begin
      AST_FIND_HIT: assert (req_i[idx_o]);                                      // R3
      AST_FIND_LOWEST: assert ((req_i & ((W'(1) << idx_o) - W'(1))) == '0);    // R3
    end
  end
endmodule

// File: rtl/grp_irq_boost_split.sv
module grp_irq_boost_split #(
  parameter int N = 32
) (
  input  logic [N-1:0]   pend_i,
  input  logic [2*N-1:0] boost_i,
  output logic [N-1:0]   hi_o,
  output logic [N-1:0]   med_o,
  output logic [N-1:0]   norm_o
);
  for (genvar p = 0; p < N; p++) begin : g_cls
    assign hi_o[p]   = pend_i[p] & boost_i[2*p+1];
    assign med_o[p]  = pend_i[p] & ~boost_i[2*p+1] & boost_i[2*p];
    assign norm_o[p] = pend_i[p] & ~boost_i[2*p+1] & ~boost_i[2*p];
  end
endmodule

// File: rtl/grp_irq_encoder.sv
module grp_irq_encoder
  import grp_irq_pkg::*;
#(
  parameter int N_CRIT = 4,
  parameter int N_MAIN = 17,
  parameter int N_PERI = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CRIT-1:0] crit_req_i,
  input  logic [N_MAIN-1:0] main_req_i,
  input  logic [N_PERI-1:0] peri_req_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       status_o,
  output logic              pend_valid_o,
  output logic [1:0]        pend_group_o,
  output logic [5:0]        pend_src_o,
  output logic [7:0]        pend_id_o
);
  logic [N_CRIT-1:0]   crit_mask;
  logic [N_MAIN-1:0]   main_mask;
  logic [N_PERI-1:0]   peri_mask;
  logic [2*N_PERI-1:0] boost;

  grp_irq_cfg #(.N_CRIT(N_CRIT), .N_MAIN(N_MAIN), .N_PERI(N_PERI), .DW(32), .AW(3)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .crit_mask_o(crit_mask), .main_mask_o(main_mask),
    .peri_mask_o(peri_mask), .boost_o(boost)
  );

  // peripheral masking (bit order mirrored) and boost classes
  logic [N_PERI-1:0] peri_pend, peri_hi, peri_med, peri_norm;
  for (genvar i = 0; i < N_PERI; i++) begin : g_peri
    assign peri_pend[i] = peri_req_i[i] & ~peri_mask[N_PERI-1-i];
  end

  grp_irq_boost_split #(.N(N_PERI)) u_split (
    .pend_i(peri_pend), .boost_i(boost),
    .hi_o(peri_hi), .med_o(peri_med), .norm_o(peri_norm)
  );

  logic hi_any, med_any;
  assign hi_any  = |peri_hi;
  assign med_any = |peri_med;

  // reserved slots carry the boosted-peripheral summaries
  logic [N_CRIT-1:0] crit_vec;
  logic [N_MAIN-1:0] main_vec;
  for (genvar i = 0; i < N_CRIT; i++) begin : g_crit
    if (i == CRIT_BOOST_IDX) begin : g_rsv
      assign crit_vec[i] = hi_any;
    end else begin : g_src
      assign crit_vec[i] = crit_req_i[i] & ~crit_mask[i];
    end
  end
  for (genvar i = 0; i < N_MAIN; i++) begin : g_main
    if (i == MAIN_BOOST_IDX) begin : g_rsv
      assign main_vec[i] = med_any;
    end else begin : g_src
      assign main_vec[i] = main_req_i[i] & ~main_mask[N_MAIN-1-i];
    end
  end

  logic               crit_f, main_f, hi_f, med_f, norm_f;
  logic [CRIT_FW-1:0] crit_idx;
  logic [MAIN_FW-1:0] main_idx;
  logic [PERI_FW-1:0] hi_idx, med_idx, norm_idx;

  grp_irq_lowest #(.W(N_CRIT), .IW(CRIT_FW)) u_crit (.req_i(crit_vec),  .found_o(crit_f), .idx_o(crit_idx));
  grp_irq_lowest #(.W(N_MAIN), .IW(MAIN_FW)) u_main (.req_i(main_vec),  .found_o(main_f), .idx_o(main_idx));
  grp_irq_lowest #(.W(N_PERI), .IW(PERI_FW)) u_hi   (.req_i(peri_hi),   .found_o(hi_f),   .idx_o(hi_idx));
  grp_irq_lowest #(.W(N_PERI), .IW(PERI_FW)) u_med  (.req_i(peri_med),  .found_o(med_f),  .idx_o(med_idx));
  grp_irq_lowest #(.W(N_PERI), .IW(PERI_FW)) u_norm (.req_i(peri_norm), .found_o(norm_f), .idx_o(norm_idx));

  logic               peri_f;
  logic [PERI_FW-1:0] peri_idx;
  assign peri_f   = hi_f | med_f | norm_f;
  assign peri_idx = hi_f ? hi_idx : (med_f ? med_idx : norm_idx);

  logic [31:0]      st_d;
  logic             vld_d;
  grp_e             grp_d;
  logic [SRC_W-1:0] src_d;

  always_comb begin
    st_d = '0;
    st_d[CRIT_FLAG_BIT]           = crit_f;
    st_d[CRIT_LSB +: CRIT_FW]     = crit_idx;
    st_d[MAIN_FLAG_BIT]           = main_f;
    st_d[MAIN_LSB +: MAIN_FW]     = main_idx;
    st_d[PERI_FLAG_BIT]           = peri_f;
    st_d[PERI_LSB +: PERI_FW]     = peri_idx;

    vld_d = crit_f | main_f | peri_f;
    grp_d = GRP_CRIT;
    src_d = '0;
    if (crit_f) begin
      if (crit_idx == CRIT_FW'(CRIT_BOOST_IDX)) begin
        grp_d = GRP_PERI;
        src_d = SRC_W'(peri_idx);
      end else begin
        src_d = SRC_W'(crit_idx);
      end
    end else if (main_f) begin
      if (main_idx == MAIN_FW'(MAIN_BOOST_IDX)) begin
        grp_d = GRP_PERI;
        src_d = SRC_W'(peri_idx);
      end else begin
        grp_d = GRP_MAIN;
        src_d = SRC_W'(main_idx);
      end
    end else if (peri_f) begin
      grp_d = GRP_PERI;
      src_d = SRC_W'(peri_idx);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o     <= '0;
      pend_valid_o <= 1'b0;
      pend_group_o <= '0;
      pend_src_o   <= '0;
    end else begin
      status_o     <= st_d;
      pend_valid_o <= vld_d;
      pend_group_o <= grp_d;
      pend_src_o   <= src_d;
    end
  end

  assign pend_id_o = {pend_group_o, pend_src_o};

  AST_CRIT_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[CRIT_FLAG_BIT] && status_o[CRIT_LSB +: CRIT_FW] == CRIT_FW'(CRIT_BOOST_IDX))
    |-> (status_o[PERI_FLAG_BIT] && pend_group_o == GRP_PERI
         && pend_src_o == SRC_W'(status_o[PERI_LSB +: PERI_FW])));                        // R6
  AST_MAIN_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[CRIT_FLAG_BIT] && status_o[MAIN_FLAG_BIT]
     && status_o[MAIN_LSB +: MAIN_FW] == MAIN_FW'(MAIN_BOOST_IDX))
    |-> (status_o[PERI_FLAG_BIT] && pend_group_o == GRP_PERI));                            // R6
  AST_GROUP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_o && pend_group_o != GRP_CRIT) |-> !status_o[CRIT_FLAG_BIT]
      || status_o[CRIT_LSB +: CRIT_FW] == CRIT_FW'(CRIT_BOOST_IDX));                       // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_valid_o |-> (pend_id_o == '0 && !status_o[CRIT_FLAG_BIT]
      && !status_o[MAIN_FLAG_BIT] && !status_o[PERI_FLAG_BIT]));                           // R9
  AST_QUIET_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_req_i == '0 && main_req_i == '0 && peri_req_i == '0) |=> !pend_valid_o);        // R10
  AST_RSVD_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_req_i[CRIT_BOOST_IDX] && main_req_i[MAIN_BOOST_IDX] && !hi_any && !med_any
     && (crit_req_i & ~crit_mask) == (N_CRIT'(1) << CRIT_BOOST_IDX)
     && (main_vec == '0) && peri_pend == '0)
    |=> !pend_valid_o);                                                                    // R5
endmodule

// File: tb/grp_irq_encoder_test.sv
`timescale 1ns/1ps
module grp_irq_encoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  crq = '0;
  logic [16:0] mrq = '0;
  logic [31:0] prq = '0;
  logic        wen = 1'b0;
  logic [2:0]  wad = '0;
  logic [31:0] wdt = '0;
  logic [31:0] status;
  logic        pv;
  logic [1:0]  pg;
  logic [5:0]  ps;
  logic [7:0]  pid;

  grp_irq_encoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .crit_req_i(crq), .main_req_i(mrq), .peri_req_i(prq),
    .wr_en_i(wen), .wr_addr_i(wad), .wr_data_i(wdt),
    .status_o(status), .pend_valid_o(pv), .pend_group_o(pg), .pend_src_o(ps), .pend_id_o(pid)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0, chk_en = 0;
  string tag = "R1";

  bit [3:0]  m_cm;
  bit [16:0] m_mm;
  bit [31:0] m_pm;
  bit [1:0]  m_bst [32];
  bit [31:0] e_st;
  bit [8:0]  e_cmb;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic void calc();
    int cc = -1, mc = -1, ph = -1, pmd = -1, pn = -1, pc;
    int grp = 0, src = 0;
    bit vld;
    for (int n = 0; n < 32; n++) begin
      if (prq[n] && !m_pm[31-n]) begin
        if (m_bst[n][1])        begin if (ph  < 0) ph  = n; end
        else if (m_bst[n] == 1) begin if (pmd < 0) pmd = n; end
        else                    begin if (pn  < 0) pn  = n; end
      end
    end
    pc = (ph >= 0) ? ph : ((pmd >= 0) ? pmd : pn);
    for (int i = 0; i < 4; i++) begin
      if (cc < 0 && ((i == 2) ? (ph >= 0) : (crq[i] && !m_cm[i]))) cc = i;
    end
    for (int i = 0; i < 17; i++) begin
      if (mc < 0 && ((i == 4) ? (pmd >= 0) : (mrq[i] && !m_mm[16-i]))) mc = i;
    end
    e_st = '0;
    if (cc >= 0) e_st = e_st | 32'h400 | (32'(cc) << 8);
    if (mc >= 0) e_st = e_st | 32'h0020_0000 | (32'(mc) << 16);
    if (pc >= 0) e_st = e_st | 32'h2000_0000 | (32'(pc) << 24);
    vld = (cc >= 0) || (mc >= 0) || (pc >= 0);
    if (cc >= 0) begin
      if (cc == 2) begin grp = 2; src = pc; end else src = cc;
    end else if (mc >= 0) begin
      if (mc == 4) begin grp = 2; src = pc; end else begin grp = 1; src = mc; end
    end else if (pc >= 0) begin
      grp = 2; src = pc;
    end
    e_cmb = {vld, 8'(grp * 64 + src)};
  endfunction

  // cycle-by-cycle reference model
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cm = '1; m_mm = '1; m_pm = '1;
      for (int k = 0; k < 32; k++) m_bst[k] = 2'b00;
      e_st = '0; e_cmb = '0;
    end else begin
      calc();
      if (wen) begin
        case (wad)
          3'd0: m_cm = wdt[3:0];
          3'd1: m_mm = wdt[16:0];
          3'd2: m_pm = wdt;
          3'd3: for (int k = 0; k < 16; k++) m_bst[k] = wdt[2*k +: 2];
          3'd4: for (int k = 0; k < 16; k++) m_bst[16+k] = wdt[2*k +: 2];
          default: ;
        endcase
      end
    end
    #1;
    if (rst_ni && chk_en) begin
      check(tag, status, e_st, "status");
      check(tag, {23'd0, pv, pid}, {23'd0, e_cmb}, "valid/id");
      if (pid !== {pg, ps}) check(tag, {24'd0, pid}, {24'd0, pg, ps}, "id packing R9");
    end
  end

  task automatic drive(bit [3:0] c, bit [16:0] m, bit [31:0] p);
    @(negedge clk); crq = c; mrq = m; prq = p;
  endtask

  task automatic cfg(int a, bit [31:0] d);
    @(negedge clk); wen = 1'b1; wad = 3'(a); wdt = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic dchk(string t, bit [31:0] st, bit v, bit [7:0] id);
    @(posedge clk); #2;
    check(t, status, st, "direct status");
    check(t, {23'd0, pv, pid}, {23'd0, v, id}, "direct valid/id");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", status, 32'h0, "status in reset");
    check("R1", {31'd0, pv}, 32'h0, "valid in reset");
    rst_ni = 1'b1;
    chk_en = 1;
    // R1: masks default to disabled
    drive(4'hF, 17'h1FFFF, 32'hFFFF_FFFF);
    dchk("R1", 32'h0, 1'b0, 8'h00);
    drive(4'hF, 17'h1FFFF, 32'hFFFF_FFFF);
    dchk("R1", 32'h0, 1'b0, 8'h00);

    // R4: mask bit mirroring
    tag = "R4";
    cfg(0, 0); cfg(1, 32'h0001_0000); cfg(2, 32'h8000_0000);
    drive(4'h0, 17'h00003, 32'h0000_0003);
    dchk("R4", 32'h2121_0000, 1'b1, 8'h41);
    cfg(1, 0); cfg(2, 0);

    // R3: lowest index wins
    tag = "R3";
    drive(4'b1010, 17'h1_0100, 32'h0000_F0F0);
    dchk("R3", 32'h2428_0500, 1'b1, 8'h01);

    // R5: reserved raw lines
    tag = "R5";
    drive(4'b0100, 17'h0, 32'h0);
    dchk("R5", 32'h0, 1'b0, 8'h00);
    drive(4'b0000, 17'h0_0010, 32'h0);
    dchk("R5", 32'h0, 1'b0, 8'h00);

    // R11 / R6: boost register layout and redirection
    tag = "R11";
    cfg(3, 32'h000C_0000 & 32'h0008_0000);   // peripheral 9 high (10)
    cfg(4, 32'h0000_0100);                   // peripheral 20 medium (01)
    cfg(5, 32'hFFFF_FFFF);                   // ignored address
    tag = "R6";
    drive(4'h0, 17'h0, 32'h0000_0200);
    dchk("R6", 32'h2900_0600, 1'b1, 8'h89);
    drive(4'h0, 17'h0, 32'h0010_0000);
    dchk("R6", 32'h3424_0000, 1'b1, 8'h94);

    // R7: peripheral class order
    tag = "R7";
    drive(4'h0, 17'h0, 32'h0010_0208);
    dchk("R7", 32'h2924_0600, 1'b1, 8'h89);
    drive(4'h0, 17'h0, 32'h0010_0008);
    dchk("R7", 32'h3424_0000, 1'b1, 8'h94);

    // R8: group priority
    tag = "R8";
    drive(4'b0001, 17'h00001, 32'h0010_0000);
    dchk("R8", 32'h3420_0400, 1'b1, 8'h00);
    drive(4'h0, 17'h00002, 32'h0000_0008);
    dchk("R8", 32'h2321_0000, 1'b1, 8'h41);
    drive(4'h0, 17'h0, 32'h0000_0001);
    dchk("R8", 32'h2000_0000, 1'b1, 8'h80);

    // R9: idle
    tag = "R9";
    drive(4'h0, 17'h0, 32'h0);
    dchk("R9", 32'h0, 1'b0, 8'h00);

    // R10: one-edge latency, write effect timing
    tag = "R10";
    @(negedge clk); crq = 4'b0001; #1;
    check("R10", {31'd0, pv}, 32'h0, "valid before edge");
    @(posedge clk); #2;
    check("R10", {31'd0, pv}, 32'h1, "valid after edge");
    cfg(0, 32'h1);
    @(posedge clk); #2;
    check("R10", {31'd0, pv}, 32'h0, "masked after write");
    cfg(0, 0);

    // R2: random traffic against the model
    tag = "R2";
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      crq = 4'($urandom() & $urandom());
      mrq = 17'($urandom() & $urandom() & $urandom());
      prq = $urandom() & $urandom() & $urandom();
      wen = ($urandom() % 8) == 0;
      wad = 3'($urandom());
      wdt = $urandom() | $urandom();
    end
    @(negedge clk); wen = 1'b0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule